// File: doc/BRIEF.md
# Software-Managed Unified Translation Buffer

The block is a 64-entry, fully associative translation buffer for a core with 32-bit effective addresses and 36-bit physical addresses. Instruction fetches and data accesses share one entry array. Every cycle it can translate one fetch address and one data address, and it can run one software search. Each entry holds a valid bit, a one-bit address-space tag, a 4-bit page-size code, an effective page number and a physical page number. Nothing in hardware refills entries or picks a victim. Software decides which entry to load and supplies the index on the write port.

A fetch matches only entries whose space tag equals the instruction-space bit. A data access matches only entries whose tag equals the data-space bit. While an exception is being taken, both bits are treated as 0, so translation carries on in space 0. Translation is never bypassed. One entry comes out of reset valid and maps the reset vector, so the first fetches hit. Translate and search results appear one clock after the request. A lookup that finds no matching entry gives a one-cycle miss pulse on its own port and captures the faulting address.

Top module: `soft_tlb`

## Requirements
- R1: All 64 entries are shared. An entry written at any index from 0 to 63 is seen by fetch, data and search lookups from the next cycle on.
- R2: The page-size code c gives a page of 1KB·4^c, and the legal codes are 0,1,2,3,4,5,7,9. For a hit, bits [9+2c:0] of the physical output equal the same bits of the request address. The bits above come from the stored physical page number. Effective and physical page bits below the page boundary are ignored.
- R3: A write with the valid field 1 and a size code of 6, 8 or 10 to 15 leaves the array unchanged. It makes `wr_err_o` 1 in the cycle after the write. Every other write makes `wr_err_o` 0 in the cycle after the write.
- R4: A fetch matches only entries whose tag equals `ispace_i`. A data access matches only entries whose tag equals `dspace_i`.
- R5: While `exc_take_i` is 1, fetch and data lookups in that cycle use space 0, whatever `ispace_i` and `dspace_i` are.
- R6: After reset, entry 0 is valid with tag 0 and a 4KB page. It maps effective 0xFFFFF000 to physical 0xFFFFFF000.
- R7: A search returns a hit flag and the index of the matching entry one cycle later. It changes no entry.
- R8: Translate outputs are registered, one cycle after the request. On a miss the port's miss output is 1 for one cycle and its fault-address output holds the request address. With no request, both hit and miss are 0.
- R9: When several valid entries match, the lowest-numbered one supplies the index and the physical address.
- R10: Writing an entry with the valid field 0 removes that entry alone.
- R11: `inv_all_i` clears every valid bit except entry 0's. Entry 0 is spared only until software first rewrites it.
- R12: The physical output is 36 bits wide, and a mapping can reach above 4GB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ispace_i | input | 1 | Instruction address-space bit |
| dspace_i | input | 1 | Data address-space bit |
| exc_take_i | input | 1 | Exception being taken; forces space 0 for this cycle's lookups |
| if_req_i | input | 1 | Fetch translate request |
| if_va_i | input | 32 | Fetch effective address |
| if_hit_o | output | 1 | Fetch hit |
| if_miss_o | output | 1 | Fetch miss pulse |
| if_idx_o | output | 6 | Entry that translated the fetch |
| if_pa_o | output | 36 | Fetch physical address |
| if_fault_va_o | output | 32 | Last fetch address that missed |
| d_req_i | input | 1 | Data translate request |
| d_va_i | input | 32 | Data effective address |
| d_hit_o | output | 1 | Data hit |
| d_miss_o | output | 1 | Data miss pulse |
| d_idx_o | output | 6 | Entry that translated the data access |
| d_pa_o | output | 36 | Data physical address |
| d_fault_va_o | output | 32 | Last data address that missed |
| sr_req_i | input | 1 | Search request |
| sr_va_i | input | 32 | Search address |
| sr_space_i | input | 1 | Search address space |
| sr_hit_o | output | 1 | Search hit |
| sr_idx_o | output | 6 | Search matching index |
| sr_pa_o | output | 36 | Physical address found by the search |
| wr_en_i | input | 1 | Entry write strobe |
| wr_idx_i | input | 6 | Entry index to write |
| wr_valid_i | input | 1 | Valid field of the written entry |
| wr_space_i | input | 1 | Space tag of the written entry |
| wr_size_i | input | 4 | Page-size code of the written entry |
| wr_epn_i | input | 22 | Effective page number, address bits [31:10] |
| wr_ppn_i | input | 26 | Physical page number, address bits [35:10] |
| inv_all_i | input | 1 | Clear all valid bits except the spared reset entry |
| wr_err_o | output | 1 | Rejected-size flag for the previous write |

## Verification
The assertions assume every input is known after reset. They also assume that a write or a global clear is the only thing that may change the array in a cycle. This is why the unchanged-array checks leave out cycles that also carry a write or a clear. The bench changes inputs only on the falling edge and gives each write, clear, search or translation a cycle of its own. It keeps a model of the array and sweeps every size code, both space values, offsets at the page edges and addresses one page beyond each mapping. It then checks each result against page arithmetic done in the bench.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 36;
  localparam int PG_MIN = 10;
  localparam int EPN_W  = VA_W - PG_MIN;
  localparam int PPN_W  = PA_W - PG_MIN;
  localparam int SZ_W   = 4;

  typedef struct packed {
    logic             valid;
    logic             space;
    logic [SZ_W-1:0]  size;
    logic [EPN_W-1:0] epn;
    logic [PPN_W-1:0] ppn;
  } tlb_entry_t;

  // legal page-size codes: 1KB..256MB in powers of four, minus 4MB and 64MB
  function automatic logic size_ok(input logic [SZ_W-1:0] c);
    return (c <= 4'd9) && (c != 4'd6) && (c != 4'd8);
  endfunction

  // page-number bits that fall inside the page offset for size code c
  function automatic logic [EPN_W-1:0] size_mask(input logic [SZ_W-1:0] c);
    logic [EPN_W-1:0] m;
    for (int i = 0; i < EPN_W; i++) m[i] = (i < 2 * int'(c));
    return m;
  endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int         N         = 64,
  parameter int         IDX_W     = $clog2(N),
  parameter int         RST_IDX   = 0,
  parameter tlb_entry_t RST_ENTRY = '0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  tlb_entry_t           wr_data_i,
  input  logic                 inv_all_i,
  output tlb_entry_t [N-1:0]   ent_o,
  output logic                 wr_err_o
);
  tlb_entry_t [N-1:0] ent_q;
  logic pinned_q, wr_err_q;
  logic bad_size, wr_take;

  assign bad_size = wr_data_i.valid && !size_ok(wr_data_i.size);
  assign wr_take  = wr_en_i && !bad_size;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q          <= '0;
      ent_q[RST_IDX] <= RST_ENTRY;
      pinned_q       <= 1'b1;
      wr_err_q       <= 1'b0;
    end else begin
      wr_err_q <= wr_en_i && bad_size;
      if (inv_all_i) begin
        for (int i = 0; i < N; i++)
          if (!(pinned_q && i == RST_IDX)) ent_q[i].valid <= 1'b0;
      end
      if (wr_take) begin
        ent_q[wr_idx_i] <= wr_data_i;
        if (wr_idx_i == IDX_W'(RST_IDX)) pinned_q <= 1'b0;
      end
    end
  end

  assign ent_o    = ent_q;
  assign wr_err_o = wr_err_q;

  assert_bad_size_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i.valid && !size_ok(wr_data_i.size)) |=> wr_err_o);
  assert_bad_size_keep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i.valid && !size_ok(wr_data_i.size) && !inv_all_i) |=> $stable(ent_q));
  assert_pinned_keep_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_all_i && pinned_q && !(wr_en_i && wr_idx_i == IDX_W'(RST_IDX))) |=> ent_q[RST_IDX].valid);
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  tlb_entry_t [N-1:0] ent_i,
  input  logic [VA_W-1:0]    va_i,
  input  logic               space_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [PA_W-1:0]    pa_o
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic [EPN_W-1:0] m;
    assign m        = size_mask(ent_i[g].size);
    assign match[g] = ent_i[g].valid && (ent_i[g].space == space_i) &&
                      (((va_i[VA_W-1:PG_MIN] ^ ent_i[g].epn) & ~m) == '0);
  end

  // lowest index wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  tlb_entry_t       sel;
  logic [PPN_W-1:0] sel_m;
  assign sel   = ent_i[idx_o];
  assign sel_m = {{(PPN_W-EPN_W){1'b0}}, size_mask(sel.size)};
  assign pa_o  = {(sel.ppn & ~sel_m) | ({{(PPN_W-EPN_W){1'b0}}, va_i[VA_W-1:PG_MIN]} & sel_m),
                  va_i[PG_MIN-1:0]};
endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
  import tlb_pkg::*;
#(
  parameter int              N_ENTRIES = 64,
  parameter int              IDX_W     = $clog2(N_ENTRIES),
  parameter int              RST_IDX   = 0,
  parameter logic [VA_W-1:0] RST_VA    = 32'hFFFF_F000,
  parameter logic [PA_W-1:0] RST_PA    = 36'hF_FFFF_F000,
  parameter logic [SZ_W-1:0] RST_SIZE  = 4'd1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ispace_i,
  input  logic             dspace_i,
  input  logic             exc_take_i,
  input  logic             if_req_i,
  input  logic [31:0]      if_va_i,
  output logic             if_hit_o,
  output logic             if_miss_o,
  output logic [IDX_W-1:0] if_idx_o,
  output logic [35:0]      if_pa_o,
  output logic [31:0]      if_fault_va_o,
  input  logic             d_req_i,
  input  logic [31:0]      d_va_i,
  output logic             d_hit_o,
  output logic             d_miss_o,
  output logic [IDX_W-1:0] d_idx_o,
  output logic [35:0]      d_pa_o,
  output logic [31:0]      d_fault_va_o,
  input  logic             sr_req_i,
  input  logic [31:0]      sr_va_i,
  input  logic             sr_space_i,
  output logic             sr_hit_o,
  output logic [IDX_W-1:0] sr_idx_o,
  output logic [35:0]      sr_pa_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_valid_i,
  input  logic             wr_space_i,
  input  logic [3:0]       wr_size_i,
  input  logic [21:0]      wr_epn_i,
  input  logic [25:0]      wr_ppn_i,
  input  logic             inv_all_i,
  output logic             wr_err_o
);
  localparam int         LANES     = 3;  // fetch, data, search
  localparam tlb_entry_t RST_ENTRY = '{valid: 1'b1, space: 1'b0, size: RST_SIZE,
                                       epn: RST_VA[VA_W-1:PG_MIN], ppn: RST_PA[PA_W-1:PG_MIN]};

  tlb_entry_t [N_ENTRIES-1:0] ent;
  tlb_entry_t                 wr_data;

  assign wr_data = '{valid: wr_valid_i, space: wr_space_i, size: wr_size_i,
                     epn: wr_epn_i, ppn: wr_ppn_i};

  tlb_store #(.N(N_ENTRIES), .IDX_W(IDX_W), .RST_IDX(RST_IDX), .RST_ENTRY(RST_ENTRY)) u_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_data_i(wr_data), .inv_all_i,
    .ent_o(ent), .wr_err_o
  );

  logic [VA_W-1:0]  ln_va  [LANES];
  logic             ln_sp  [LANES];
  logic             ln_req [LANES];
  logic             ln_hit [LANES];
  logic [IDX_W-1:0] ln_idx [LANES];
  logic [PA_W-1:0]  ln_pa  [LANES];
  logic             hit_q  [LANES];
  logic [IDX_W-1:0] idx_q  [LANES];
  logic [PA_W-1:0]  pa_q   [LANES];
  logic             miss_q [2];
  logic [VA_W-1:0]  fva_q  [2];

  // exception entry forces space 0
  assign ln_va[0]  = if_va_i;
  assign ln_sp[0]  = ispace_i & ~exc_take_i;
  assign ln_req[0] = if_req_i;
  assign ln_va[1]  = d_va_i;
  assign ln_sp[1]  = dspace_i & ~exc_take_i;
  assign ln_req[1] = d_req_i;
  assign ln_va[2]  = sr_va_i;
  assign ln_sp[2]  = sr_space_i;
  assign ln_req[2] = sr_req_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tlb_match #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_match (
      .ent_i(ent), .va_i(ln_va[g]), .space_i(ln_sp[g]),
      .hit_o(ln_hit[g]), .idx_o(ln_idx[g]), .pa_o(ln_pa[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hit_q[g] <= 1'b0;
        idx_q[g] <= '0;
        pa_q[g]  <= '0;
      end else begin
        hit_q[g] <= ln_req[g] && ln_hit[g];
        if (ln_req[g]) begin
          idx_q[g] <= ln_idx[g];
          pa_q[g]  <= ln_pa[g];
        end
      end
    end

    if (g < 2) begin : g_miss
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          miss_q[g] <= 1'b0;
          fva_q[g]  <= '0;
        end else begin
          miss_q[g] <= ln_req[g] && !ln_hit[g];
          if (ln_req[g] && !ln_hit[g]) fva_q[g] <= ln_va[g];
        end
      end
    end
  end

  assign if_hit_o      = hit_q[0];
  assign if_miss_o     = miss_q[0];
  assign if_idx_o      = idx_q[0];
  assign if_pa_o       = pa_q[0];
  assign if_fault_va_o = fva_q[0];
  assign d_hit_o       = hit_q[1];
  assign d_miss_o      = miss_q[1];
  assign d_idx_o       = idx_q[1];
  assign d_pa_o        = pa_q[1];
  assign d_fault_va_o  = fva_q[1];
  assign sr_hit_o      = hit_q[2];
  assign sr_idx_o      = idx_q[2];
  assign sr_pa_o       = pa_q[2];

  assert_hit_miss_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(if_hit_o && if_miss_o) && !(d_hit_o && d_miss_o));
  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!if_req_i && !d_req_i) |=> (!if_hit_o && !if_miss_o && !d_hit_o && !d_miss_o));
  assert_req_answered_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_req_i |=> (d_hit_o != d_miss_o));
  assert_fault_va_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_req_i |=> (!if_miss_o || if_fault_va_o == $past(if_va_i)));
  assert_search_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_req_i && !wr_en_i && !inv_all_i) |=> $stable(ent));
endmodule

// File: tb/soft_tlb_bench.sv
module soft_tlb_bench;
  localparam int N = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ispace = 0, dspace = 0, exc = 0;
  logic if_req = 0, d_req = 0, sr_req = 0, sr_sp = 0;
  logic [31:0] if_va = 0, d_va = 0, sr_va = 0;
  logic if_hit, if_miss, d_hit, d_miss, sr_hit, wr_err;
  logic [5:0] if_idx, d_idx, sr_idx;
  logic [35:0] if_pa, d_pa, sr_pa;
  logic [31:0] if_fva, d_fva;
  logic wr_en = 0, wr_v = 0, wr_sp = 0, inv_all = 0;
  logic [5:0] wr_idx = 0;
  logic [3:0] wr_sz = 0;
  logic [21:0] wr_epn = 0;
  logic [25:0] wr_ppn = 0;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  soft_tlb u_soft_tlb (
    .clk_i(clk), .rst_ni(rst_n), .ispace_i(ispace), .dspace_i(dspace), .exc_take_i(exc),
    .if_req_i(if_req), .if_va_i(if_va), .if_hit_o(if_hit), .if_miss_o(if_miss),
    .if_idx_o(if_idx), .if_pa_o(if_pa), .if_fault_va_o(if_fva),
    .d_req_i(d_req), .d_va_i(d_va), .d_hit_o(d_hit), .d_miss_o(d_miss),
    .d_idx_o(d_idx), .d_pa_o(d_pa), .d_fault_va_o(d_fva),
    .sr_req_i(sr_req), .sr_va_i(sr_va), .sr_space_i(sr_sp), .sr_hit_o(sr_hit),
    .sr_idx_o(sr_idx), .sr_pa_o(sr_pa),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_valid_i(wr_v), .wr_space_i(wr_sp),
    .wr_size_i(wr_sz), .wr_epn_i(wr_epn), .wr_ppn_i(wr_ppn), .inv_all_i(inv_all),
    .wr_err_o(wr_err)
  );

  // bench model of the array
  logic        m_valid [N];
  logic        m_sp    [N];
  logic [3:0]  m_size  [N];
  logic [21:0] m_epn   [N];
  logic [25:0] m_ppn   [N];
  logic        m_pinned;

  function automatic bit legal(input logic [3:0] c);
    return (c <= 9) && (c != 6) && (c != 8);
  endfunction

  function automatic void model_lookup(input logic [31:0] va, input logic sp,
                                       output logic h, output int ix, output logic [35:0] pa);
    h = 0; ix = 0; pa = 0;
    for (int i = N - 1; i >= 0; i--) begin
      if (m_valid[i] && m_sp[i] == sp) begin
        int ob;
        longint vp, pp;
        ob = 10 + 2 * int'(m_size[i]);
        vp = longint'({m_epn[i], 10'b0});
        pp = longint'({m_ppn[i], 10'b0});
        if (((longint'(va) ^ vp) >> ob) == 0) begin
          h  = 1;
          ix = i;
          pa = 36'(((pp >> ob) << ob) | (longint'(va) & ((longint'(1) << ob) - 1)));
        end
      end
    end
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input int idx, input logic v, input logic sp, input logic [3:0] sz,
                          input logic [21:0] epn, input logic [25:0] ppn, input string tag);
    bit bad;
    @(negedge clk);
    wr_en = 1; wr_idx = 6'(idx); wr_v = v; wr_sp = sp; wr_sz = sz; wr_epn = epn; wr_ppn = ppn;
    @(negedge clk);
    wr_en = 0;
    bad = v && !legal(sz);
    chk(wr_err == bad, {tag, " R3 write flag"}, 64'(wr_err), 64'(bad));
    if (!bad) begin
      m_valid[idx] = v; m_sp[idx] = sp; m_size[idx] = sz; m_epn[idx] = epn; m_ppn[idx] = ppn;
      if (idx == 0) m_pinned = 0;
    end
  endtask

  task automatic do_inv_all();
    @(negedge clk);
    inv_all = 1;
    @(negedge clk);
    inv_all = 0;
    for (int i = 0; i < N; i++) if (!(m_pinned && i == 0)) m_valid[i] = 0;
  endtask

  task automatic do_xlat(input logic [31:0] iva, input logic is, input logic [31:0] dva,
                         input logic ds, input logic ex, input string tag);
    logic ih, dh;
    int ii, di;
    logic [35:0] ip, dp;
    @(negedge clk);
    if_req = 1; if_va = iva; d_req = 1; d_va = dva; ispace = is; dspace = ds; exc = ex;
    model_lookup(iva, is & ~ex, ih, ii, ip);
    model_lookup(dva, ds & ~ex, dh, di, dp);
    @(negedge clk);
    if_req = 0; d_req = 0; exc = 0;
    chk(if_hit == ih && if_miss == !ih, {tag, " fetch hit/miss"}, 64'({if_hit, if_miss}), 64'({ih, !ih}));
    if (ih) begin
      chk(if_pa == ip, {tag, " fetch pa"}, 64'(if_pa), 64'(ip));
      chk(int'(if_idx) == ii, {tag, " fetch idx"}, 64'(if_idx), 64'(ii));
    end else
      chk(if_fva == iva, {tag, " R8 fetch fault va"}, 64'(if_fva), 64'(iva));
    chk(d_hit == dh && d_miss == !dh, {tag, " data hit/miss"}, 64'({d_hit, d_miss}), 64'({dh, !dh}));
    if (dh) begin
      chk(d_pa == dp, {tag, " data pa"}, 64'(d_pa), 64'(dp));
      chk(int'(d_idx) == di, {tag, " data idx"}, 64'(d_idx), 64'(di));
    end else
      chk(d_fva == dva, {tag, " R8 data fault va"}, 64'(d_fva), 64'(dva));
  endtask

  task automatic do_search(input logic [31:0] va, input logic sp, input string tag);
    logic h;
    int ix;
    logic [35:0] pa;
    @(negedge clk);
    sr_req = 1; sr_va = va; sr_sp = sp;
    model_lookup(va, sp, h, ix, pa);
    @(negedge clk);
    sr_req = 0;
    chk(sr_hit == h, {tag, " search hit"}, 64'(sr_hit), 64'(h));
    if (h) chk(int'(sr_idx) == ix, {tag, " search idx"}, 64'(sr_idx), 64'(ix));
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_sp[i] = 0; m_size[i] = 0; m_epn[i] = 0; m_ppn[i] = 0;
    end
    m_valid[0] = 1; m_size[0] = 4'd1; m_epn[0] = 22'(32'hFFFF_F000 >> 10);
    m_ppn[0] = 26'(36'hF_FFFF_F000 >> 10); m_pinned = 1;

    #35 rst_n = 1;
    @(negedge clk);
    chk(!if_hit && !if_miss && !d_hit && !d_miss && !sr_hit && !wr_err, "R8 reset outputs quiet",
        64'({if_hit, if_miss, d_hit, d_miss, sr_hit, wr_err}), 64'(0));

    // R6 R12 reset mapping; R4 data in space 1 misses it
    do_xlat(32'hFFFF_F123, 1'b0, 32'hFFFF_F004, 1'b1, 1'b0, "R6 R12 R4 reset entry");
    chk(if_pa == 36'hF_FFFF_F123, "R6 reset entry pa", 64'(if_pa), 64'h F_FFFF_F123);

    // R2 R4 R12 size sweep with junk below page boundary
    for (int c = 0; c <= 9; c++) begin
      if (legal(4'(c))) begin
        logic [31:0] base, psz;
        logic [21:0] ej;
        logic [25:0] pj;
        logic sp;
        sp   = 1'(c);
        base = 32'(c + 1) << 28;
        psz  = 32'd1 << (10 + 2 * c);
        ej   = 22'((longint'(1) << (2 * c)) - 1) & 22'h2AAAAA;
        pj   = 26'((longint'(1) << (2 * c)) - 1) & 26'h1555555;
        do_write(10 + c, 1'b1, sp, 4'(c), 22'(base >> 10) | ej, (26'(c + 1) << 22) | pj, "R2 size write");
        do_xlat(base | (32'h0DEA_DBEE & (psz - 1)), sp, base | (psz - 1), sp, 1'b0, "R2 R12 sweep hit");
        do_xlat(base, ~sp, base + psz, sp, 1'b0, "R4 R2 sweep wrong space / next page");
        do_xlat(base | 32'h0000_0155 & (psz - 1), sp, base + psz - 1, ~sp, 1'b0, "R4 data space");
      end
    end

    // R5 exception forces space 0
    do_xlat(32'h1000_0004, 1'b1, 32'h3000_0100, 1'b1, 1'b1, "R5 exception AS0");
    chk(if_hit && d_hit, "R5 both hit under exception", 64'({if_hit, d_hit}), 64'h3);

    // R3 rejected sizes leave entry 5 empty
    for (int c = 0; c < 16; c++) begin
      if (!legal(4'(c))) begin
        do_write(5, 1'b1, 1'b0, 4'(c), 22'(32'hC000_0000 >> 10), 26'h0ABCDE, "R3 bad size");
        do_search(32'hC000_0000, 1'b0, "R3 bad size not stored");
      end
    end

    // R1 top index
    do_write(63, 1'b1, 1'b1, 4'd3, 22'(32'hE000_0000 >> 10), 26'h3FF_0000, "R1 write 63");
    do_search(32'hE000_FFFF, 1'b1, "R1 search idx 63");
    chk(sr_idx == 6'd63, "R1 idx 63", 64'(sr_idx), 64'd63);
    do_xlat(32'hE000_1234, 1'b1, 32'hE000_0000, 1'b1, 1'b0, "R1 shared fetch data");

    // R9 priority, R10 single invalidate, R7 search keeps state
    do_write(41, 1'b1, 1'b0, 4'd5, 22'(32'hD000_0000 >> 10), 26'h100_0000, "R9 w41");
    do_write(40, 1'b1, 1'b0, 4'd5, 22'(32'hD000_0000 >> 10), 26'h200_0000, "R9 w40");
    do_search(32'hD001_2345, 1'b0, "R9 lowest of 40/41");
    chk(sr_idx == 6'd40, "R9 idx 40", 64'(sr_idx), 64'd40);
    do_write(20, 1'b1, 1'b0, 4'd2, 22'(32'hD000_0000 >> 10), 26'h300_0000, "R9 w20");
    do_xlat(32'hD000_0010, 1'b0, 32'hD000_8010, 1'b0, 1'b0, "R9 R7 lowest after search");
    do_write(20, 1'b0, 1'b0, 4'd6, 22'h0, 26'h0, "R10 invalidate 20");
    do_search(32'hD000_0010, 1'b0, "R10 back to 40");
    chk(sr_idx == 6'd40, "R10 idx 40", 64'(sr_idx), 64'd40);
    do_search(32'hD000_0010, 1'b0, "R7 search repeat unchanged");

    // R11 global clear spares reset entry until rewritten
    do_inv_all();
    do_search(32'hFFFF_F800, 1'b0, "R11 pinned survives");
    chk(sr_hit && sr_idx == 0, "R11 pinned hit idx 0", 64'({sr_hit, sr_idx}), 64'h40);
    do_search(32'hD000_0000, 1'b0, "R11 others cleared");
    do_xlat(32'h1000_0000, 1'b0, 32'hE000_0000, 1'b1, 1'b0, "R11 cleared translate");
    do_write(0, 1'b1, 1'b0, 4'd9, 22'h0, 26'h0, "R11 rewrite 0");
    do_search(32'h0ABC_0000, 1'b0, "R11 rewritten hit");
    do_inv_all();
    do_search(32'h0ABC_0000, 1'b0, "R11 rewritten cleared");
    do_search(32'hFFFF_F000, 1'b0, "R11 reset va gone");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule